// File: doc/BRIEF.md
# DSP Data Address Generator

This block produces the 16-bit data-memory address for each operand access of a fixed-point DSP core, and keeps the address state that those accesses use: a 9-bit page register, eight 16-bit auxiliary address registers and a 3-bit pointer that selects one of them. A direct access joins the page register and a 7-bit offset from the instruction. An indirect access reads the selected auxiliary register and may then step that register and reload the pointer.

The address is combinational. It is valid in the cycle in which `acc_valid` is high, and it is formed from the register values held before the clock edge that closes that cycle. At that same edge the selected register takes its post-access value. The step can be plus or minus one, plus or minus register 0, or a reverse-carry sum or difference with register 0, as used for FFT bit-reversed ordering. The pointer can be reloaded at the same edge. Separate load ports let the core write the page register and any auxiliary register.

Top module: `dsp_agen`

## Requirements
- R1: After reset the page register, the pointer and all eight auxiliary registers read zero.
- R2: When `acc_valid` is high and `acc_indirect` is 0, `eff_addr` equals {page[8:0], acc_offset[6:0]}. That access changes no auxiliary register and not the pointer.
- R3: When `acc_valid` is high and `acc_indirect` is 1, `eff_addr` equals the auxiliary register selected by the pointer, taken before any update of that cycle.
- R4: Update codes on `acc_upd`: 0 and 7 leave the register unchanged; 1 adds one and 2 subtracts one, both wrapping modulo 2^16.
- R5: Code 3 adds register 0 and code 4 subtracts register 0, wrapping modulo 2^16. The register 0 value used is the one held before the edge.
- R6: Code 5 adds register 0 and code 6 subtracts register 0 with the carry or borrow running from bit 15 toward bit 0 (reverse-carry arithmetic).
- R7: During an indirect access with `acc_ptr_load` high, the pointer takes `acc_ptr_new` at the edge that ends the access. The update is applied to the previously selected register, and the next access uses the new one.
- R8: `page_we` loads `page_din` at the edge. A direct access in that same cycle still uses the old page.
- R9: `ar_we` writes `ar_wdata` into register `ar_wsel` at the edge. If that register is also the target of the post-access update in the same cycle, the write wins.
- R10: With `acc_valid` low, the update code and pointer-load inputs have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An operand access takes place this cycle |
| acc_indirect | input | 1 | 1 = register-indirect access, 0 = paged direct access |
| acc_offset | input | 7 | Low address bits for a direct access |
| acc_upd | input | 3 | Post-access update code (see R4 to R6) |
| acc_ptr_load | input | 1 | Reload the pointer after an indirect access |
| acc_ptr_new | input | 3 | New pointer value |
| page_we | input | 1 | Load the page register |
| page_din | input | 9 | New page value |
| ar_we | input | 1 | Write one auxiliary register |
| ar_wsel | input | 3 | Index of the register to write |
| ar_wdata | input | 16 | Value to write |
| eff_addr | output | 16 | Effective data address of the current access |
| ar_state | output | 128 | All auxiliary registers, register i in bits [16i+15:16i] |
| arp_q | output | 3 | Current pointer |
| page_q | output | 9 | Current page register |

## Verification
Two functions can land on the same clock edge. The first is a post-access update and a load of the same auxiliary register, including a load of register 0 while register 0 serves as the step. The second is a page load together with a direct access. The bench provokes both: directed cycles set `ar_wsel` equal to the pointer or to 0 during indexed updates, and a long random phase draws all inputs so that such overlaps occur often. A behavioural model decides each outcome from the requirements: the write beats the update, the step uses the old register 0, and the access uses the old page. The model is compared with the address and with all register state on every clock.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [2:0] {
        UPD_NONE  = 3'd0,
        UPD_INC   = 3'd1,
        UPD_DEC   = 3'd2,
        UPD_ADD0  = 3'd3,
        UPD_SUB0  = 3'd4,
        UPD_RADD0 = 3'd5,
        UPD_RSUB0 = 3'd6,
        UPD_RSVD  = 3'd7
    } upd_code_t;
endpackage

// File: rtl/agen_step.sv
module agen_step
    import agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] idx,
    input  upd_code_t     code,
    output logic [AW-1:0] nxt
);
    function automatic logic [AW-1:0] mirror(input logic [AW-1:0] v);
        logic [AW-1:0] r;
        for (int b = 0; b < AW; b++) r[b] = v[AW-1-b];
        return r;
    endfunction

    logic [AW-1:0] cur_m, idx_m, radd, rsub;

    // reverse-carry: mirror both operands, plain add/sub, mirror back (R6)
    always_comb begin
        cur_m = mirror(cur);
        idx_m = mirror(idx);
        radd  = mirror(cur_m + idx_m);
        rsub  = mirror(cur_m - idx_m);
    end

    always_comb begin
        unique case (code)
            UPD_INC:   nxt = cur + 1'b1;
            UPD_DEC:   nxt = cur - 1'b1;
            UPD_ADD0:  nxt = cur + idx;
            UPD_SUB0:  nxt = cur - idx;
            UPD_RADD0: nxt = radd;
            UPD_RSUB0: nxt = rsub;
            UPD_NONE,
            UPD_RSVD:  nxt = cur;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/agen_regfile.sv
module agen_regfile #(
    parameter int AW  = 16,
    parameter int NAR = 8,
    localparam int SW = $clog2(NAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_sel,
    input  logic [AW-1:0]     wr_data,
    input  logic              upd_en,
    input  logic [SW-1:0]     upd_sel,
    input  logic [AW-1:0]     upd_data,
    output logic [NAR*AW-1:0] regs_flat
);
    genvar gi;
    generate
        for (gi = 0; gi < NAR; gi++) begin : g_reg
            logic [AW-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    val_q <= '0;
                else if (wr_en && wr_sel == SW'(gi))      // write beats update (R9)
                    val_q <= wr_data;
                else if (upd_en && upd_sel == SW'(gi))
                    val_q <= upd_data;
            end
            assign regs_flat[gi*AW +: AW] = val_q;
        end
    endgenerate
endmodule

// File: rtl/dsp_agen.sv
module dsp_agen
    import agen_pkg::*;
#(
    parameter int AW  = 16,
    parameter int PW  = 9,
    parameter int NAR = 8,
    localparam int OW = AW - PW,
    localparam int SW = $clog2(NAR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_indirect,
    input  logic [OW-1:0]     acc_offset,
    input  logic [2:0]        acc_upd,
    input  logic              acc_ptr_load,
    input  logic [SW-1:0]     acc_ptr_new,
    input  logic              page_we,
    input  logic [PW-1:0]     page_din,
    input  logic              ar_we,
    input  logic [SW-1:0]     ar_wsel,
    input  logic [AW-1:0]     ar_wdata,
    output logic [AW-1:0]     eff_addr,
    output logic [NAR*AW-1:0] ar_state,
    output logic [SW-1:0]     arp_q,
    output logic [PW-1:0]     page_q
);
    logic [AW-1:0] ar_v [NAR];
    logic [AW-1:0] cur_ar, upd_val;
    logic          upd_en;

    genvar gi;
    generate
        for (gi = 0; gi < NAR; gi++) begin : g_view
            assign ar_v[gi] = ar_state[gi*AW +: AW];
        end
    endgenerate

    assign cur_ar = ar_v[arp_q];
    assign upd_en = acc_valid & acc_indirect;

    agen_step #(.AW(AW)) u_step (
        .cur  (cur_ar),
        .idx  (ar_v[0]),
        .code (upd_code_t'(acc_upd)),
        .nxt  (upd_val)
    );

    agen_regfile #(.AW(AW), .NAR(NAR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ar_we),
        .wr_sel    (ar_wsel),
        .wr_data   (ar_wdata),
        .upd_en    (upd_en),
        .upd_sel   (arp_q),
        .upd_data  (upd_val),
        .regs_flat (ar_state)
    );

    // state registers: page and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            arp_q  <= '0;
        end else begin
            if (page_we)
                page_q <= page_din;
            if (upd_en && acc_ptr_load)
                arp_q <= acc_ptr_new;
        end
    end

    // output: address from pre-edge state
    always_comb begin
        if (acc_indirect)
            eff_addr = cur_ar;
        else
            eff_addr = {page_q, acc_offset};
    end
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
    parameter int AW  = 16,
    parameter int PW  = 9,
    parameter int NAR = 8,
    localparam int OW = AW - PW,
    localparam int SW = $clog2(NAR)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_indirect,
    input logic [OW-1:0]     acc_offset,
    input logic [2:0]        acc_upd,
    input logic              acc_ptr_load,
    input logic [SW-1:0]     acc_ptr_new,
    input logic              page_we,
    input logic [PW-1:0]     page_din,
    input logic              ar_we,
    input logic [SW-1:0]     ar_wsel,
    input logic [AW-1:0]     ar_wdata,
    input logic [AW-1:0]     eff_addr,
    input logic [NAR*AW-1:0] ar_state,
    input logic [SW-1:0]     arp_q,
    input logic [PW-1:0]     page_q
);
    logic [AW-1:0] ar_v [NAR];
    logic [SW-1:0] prev_arp, prev_wsel;

    genvar gi;
    generate
        for (gi = 0; gi < NAR; gi++) begin : g_view
            assign ar_v[gi] = ar_state[gi*AW +: AW];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_arp  <= '0;
            prev_wsel <= '0;
        end else begin
            prev_arp  <= arp_q;
            prev_wsel <= ar_wsel;
        end
    end

    AST_DIRECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_indirect && !ar_we) |=> ($stable(ar_state) && $stable(arp_q))); // R2

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_indirect && acc_upd == 3'd1 && !(ar_we && ar_wsel == arp_q))
        |=> ar_v[prev_arp] == $past(eff_addr) + 1'b1); // R4

    AST_PTR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_indirect && acc_ptr_load) |=> arp_q == $past(acc_ptr_new)); // R7

    AST_PAGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |=> page_q == $past(page_din)); // R8

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ar_we |=> ar_v[prev_wsel] == $past(ar_wdata)); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid && !ar_we) |=> ($stable(ar_state) && $stable(arp_q))); // R10
endmodule

bind dsp_agen agen_checker #(.AW(AW), .PW(PW), .NAR(NAR)) u_agen_checker (.*);

// File: tb/dsp_agen_bench.sv
module dsp_agen_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 0, acc_indirect = 0, acc_ptr_load = 0;
    logic [6:0]  acc_offset = 0;
    logic [2:0]  acc_upd = 0, acc_ptr_new = 0, ar_wsel = 0;
    logic        page_we = 0, ar_we = 0;
    logic [8:0]  page_din = 0;
    logic [15:0] ar_wdata = 0;
    logic [15:0] eff_addr;
    logic [127:0] ar_state;
    logic [2:0]  arp_q;
    logic [8:0]  page_q;

    int checks = 0, errors = 0;
    logic [15:0] m_ar [8];
    logic [2:0]  m_arp;
    logic [8:0]  m_page;

    always #(CLK_P/2) clk = ~clk;

    dsp_agen u_dsp_agen (.*);

    function automatic logic [15:0] rc_add(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r; logic c = 1'b0; logic [1:0] s;
        for (int i = 15; i >= 0; i--) begin
            s = {1'b0, a[i]} + {1'b0, b[i]} + {1'b0, c};
            r[i] = s[0]; c = s[1];
        end
        return r;
    endfunction

    function automatic logic [15:0] rc_sub(input logic [15:0] a, input logic [15:0] b);
        logic [15:0] r; logic bw = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            r[i] = a[i] ^ b[i] ^ bw;
            bw = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & bw);
        end
        return r;
    endfunction

    task automatic check_state(input string tag);
        logic ok = (arp_q == m_arp) && (page_q == m_page);
        for (int i = 0; i < 8; i++) if (ar_state[i*16 +: 16] != m_ar[i]) ok = 1'b0;
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s state: ar=%h arp=%0d page=%h expected ar=%h%h%h%h%h%h%h%h arp=%0d page=%h",
                tag, ar_state, arp_q, page_q, m_ar[7], m_ar[6], m_ar[5], m_ar[4],
                m_ar[3], m_ar[2], m_ar[1], m_ar[0], m_arp, m_page);
        end
    endtask

    // inputs are set before the call (after a falling edge); returns after the next falling edge
    task automatic cycle(input string tag);
        logic [15:0] n_ar [8];
        logic [2:0]  n_arp;
        logic [8:0]  n_page;
        logic [15:0] cur, idx, exp_addr;
        #1;
        cur = m_ar[m_arp]; idx = m_ar[0];
        if (acc_valid) begin
            exp_addr = acc_indirect ? cur : {m_page, acc_offset};
            checks++;
            if (eff_addr != exp_addr) begin
                errors++;
                $display("FAIL %s addr: got %h expected %h", tag, eff_addr, exp_addr);
            end
        end
        for (int i = 0; i < 8; i++) n_ar[i] = m_ar[i];
        n_arp = m_arp; n_page = m_page;
        if (acc_valid && acc_indirect) begin
            case (acc_upd)
                3'd1: n_ar[m_arp] = cur + 16'd1;
                3'd2: n_ar[m_arp] = cur - 16'd1;
                3'd3: n_ar[m_arp] = cur + idx;
                3'd4: n_ar[m_arp] = cur - idx;
                3'd5: n_ar[m_arp] = rc_add(cur, idx);
                3'd6: n_ar[m_arp] = rc_sub(cur, idx);
                default: ;
            endcase
            if (acc_ptr_load) n_arp = acc_ptr_new;
        end
        if (ar_we) n_ar[ar_wsel] = ar_wdata;
        if (page_we) n_page = page_din;
        @(posedge clk); #1;
        for (int i = 0; i < 8; i++) m_ar[i] = n_ar[i];
        m_arp = n_arp; m_page = n_page;
        check_state(tag);
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 0; acc_ptr_load = 0; page_we = 0; ar_we = 0; acc_upd = 0;
    endtask

    task automatic wr_ar(input logic [2:0] s, input logic [15:0] d);
        idle(); ar_we = 1; ar_wsel = s; ar_wdata = d; cycle("R9"); ar_we = 0;
    endtask

    task automatic ind(input logic [2:0] u, input string tag);
        idle(); acc_valid = 1; acc_indirect = 1; acc_upd = u; cycle(tag);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_ar[i] = 16'h0;
        m_arp = 0; m_page = 0;
        repeat (3) @(negedge clk);
        check_state("R1");
        rst_n = 1;
        @(negedge clk);

        // R8 / R2: page load with direct access in the same cycle uses old page
        idle(); acc_valid = 1; acc_indirect = 0; acc_offset = 7'h55;
        page_we = 1; page_din = 9'h1A3; cycle("R8");
        idle(); acc_valid = 1; acc_offset = 7'h7F; acc_upd = 3'd1; cycle("R2");
        idle(); acc_valid = 1; acc_offset = 7'h00; page_we = 1; page_din = 9'h1FF; cycle("R8");
        idle(); acc_valid = 1; acc_offset = 7'h01; cycle("R2");

        // R4 wrap
        wr_ar(3'd0, 16'hFFFF);
        ind(3'd1, "R4");           // AR0 -> 0000
        ind(3'd2, "R4");           // -> FFFF
        ind(3'd0, "R4"); ind(3'd7, "R4");
        // R3/R7: pointer reload, update hits old register
        idle(); acc_valid = 1; acc_indirect = 1; acc_upd = 3'd2;
        acc_ptr_load = 1; acc_ptr_new = 3'd3; cycle("R7");
        ind(3'd1, "R3");
        // R5 indexed stepping
        wr_ar(3'd0, 16'h0010);
        ind(3'd3, "R5"); ind(3'd4, "R5"); ind(3'd4, "R5");
        // R5: AR0 written while used as index -> old AR0 used for the step
        idle(); acc_valid = 1; acc_indirect = 1; acc_upd = 3'd3;
        ar_we = 1; ar_wsel = 3'd0; ar_wdata = 16'h0100; cycle("R5");
        // R6 bit-reversed FFT ordering, step 8
        wr_ar(3'd0, 16'h0008);
        wr_ar(3'd3, 16'h0000);
        for (int k = 0; k < 16; k++) ind(3'd5, "R6");
        for (int k = 0; k < 16; k++) ind(3'd6, "R6");
        wr_ar(3'd0, 16'h8421);
        for (int k = 0; k < 6; k++) ind(3'd5, "R6");
        for (int k = 0; k < 6; k++) ind(3'd6, "R6");
        // R9 write vs update collision on the current register
        idle(); acc_valid = 1; acc_indirect = 1; acc_upd = 3'd1;
        ar_we = 1; ar_wsel = 3'd3; ar_wdata = 16'hBEEF; cycle("R9");
        ind(3'd0, "R3");
        // R10 idle cycles with update and pointer-load set
        idle(); acc_upd = 3'd3; acc_indirect = 1; acc_ptr_load = 1; acc_ptr_new = 3'd6; cycle("R10");
        idle(); acc_upd = 3'd5; acc_indirect = 1; cycle("R10");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            acc_valid    = ($urandom % 4) != 0;
            acc_indirect = $urandom % 2;
            acc_offset   = 7'($urandom);
            acc_upd      = 3'($urandom);
            acc_ptr_load = ($urandom % 3) == 0;
            acc_ptr_new  = 3'($urandom);
            page_we      = ($urandom % 5) == 0;
            page_din     = 9'($urandom);
            ar_we        = ($urandom % 3) == 0;
            ar_wsel      = ($urandom % 2) ? m_arp : 3'($urandom);
            ar_wdata     = 16'($urandom);
            cycle("R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule